// File: doc/BRIEF.md
# Masked Vector Lane Writeback Unit

This block sits between a per-element function unit and a wide vector destination register. It is built with sixteen lanes of 32 bits by default. When a request starts, it captures one operand element for each lane. An element is either the lane's own slice of the source vector or, in broadcast mode, element 0 repeated across every lane. The block then runs each lane through a fixed-latency function stage. When that stage is finished, it writes the whole destination register at once, lane by lane, under a writemask.

A lane is active when its mask bit is set or when the request uses no writemask. Active lanes take the function result. Inactive lanes either keep their previous contents (merging) or are cleared (zeroing). The invalid and divide-by-zero indications from the lanes are ORed into two vector-level flags, and only active lanes contribute. The function stage here is a parameterized placeholder. It passes the data through unchanged and derives its flags from the element's sign and magnitude bits.

A request begins with a one-cycle `start` while the unit is idle. `done` pulses for one cycle when the destination and the flags have been updated.

Top module: `vec_mask_wb`

## Requirements
- R1: Lane j occupies bits 32j+31 down to 32j of `src` and `dest`. Without broadcast, an active lane j receives the function result of its own source element. The placeholder result equals its input.
- R2: When both `bcast` and `src_is_mem` are 1, every active lane receives the result computed on `src[31:0]`.
- R3: When `bcast` is 1 but `src_is_mem` is 0, the broadcast request has no effect and each lane uses its own element.
- R4: When `mask_none` is 1, all lanes are active whatever the value of `mask`.
- R5: With `zero_mode` 0 (merging), an inactive lane keeps its previous destination value.
- R6: With `zero_mode` 1 (zeroing), an inactive lane is written with 0.
- R7: `flag_inv` is the OR, over active lanes only, of the lane invalid indication: sign bit 1 and bits 30:0 not all zero. `flag_dz` is the OR, over active lanes only, of the lane divide-by-zero indication: bits 30:0 all zero. Both flags are updated together with `dest` and hold until the next completion.
- R8: `done` is a single-cycle pulse that rises FN_LAT+1 clock cycles after the edge that accepts `start`. `dest` changes only in the cycle in which `done` is high, and then all lanes change together.
- R9: A `start` seen while `busy` is 1 is ignored. It produces no extra completion and does not disturb the request in flight.
- R10: After reset, `dest`, `flag_inv`, `flag_dz`, `done` and `busy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when idle |
| src | input | 512 | Source vector, 16 lanes of 32 bits |
| bcast | input | 1 | Broadcast element 0 request |
| src_is_mem | input | 1 | Source is a memory-style operand; broadcast takes effect only when this is set |
| mask_none | input | 1 | No writemask in use; every lane is active |
| mask | input | 16 | Per-lane writemask, bit j for lane j |
| zero_mode | input | 1 | 1 = zero inactive lanes, 0 = merge (keep) |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion pulse |
| dest | output | 512 | Destination vector register |
| flag_inv | output | 1 | Invalid summary over active lanes |
| flag_dz | output | 1 | Divide-by-zero summary over active lanes |

## Verification
The lane-selection logic is tried with distinct per-lane values, so that a swapped or replicated lane shows up at once. Broadcast is tried with and without the memory-operand qualifier, which separates a correct broadcast from one that ignores the qualifier. Sparse and empty masks are run under both merging and zeroing after the destination holds known non-zero data, which separates keeping a lane from clearing it. Lanes that raise invalid or divide-by-zero are placed inside and outside the mask, which shows whether inactive lanes leak into the flags. A start pulse issued mid-flight shows whether the captured request can be disturbed.

// File: rtl/vlw_pkg.sv
package vlw_pkg;

    typedef struct packed {
        logic inv;
        logic dz;
    } vlw_flag_t;

endpackage

// File: rtl/vlw_opsel.sv
module vlw_opsel #(
    parameter int LANES = 16,
    parameter int EW    = 32
) (
    input  logic [LANES*EW-1:0] src,
    input  logic                bcast,
    input  logic                src_is_mem,
    input  logic [LANES-1:0]    mask,
    input  logic                mask_none,
    output logic [LANES*EW-1:0] ops,
    output logic [LANES-1:0]    act
);
    logic use_elem0;

    always_comb begin
        use_elem0 = bcast & src_is_mem;
    end

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            always_comb begin
                ops[j*EW +: EW] = use_elem0 ? src[EW-1:0] : src[j*EW +: EW];
                act[j]          = mask_none | mask[j];
            end
        end
    endgenerate

endmodule

// File: rtl/vlw_lane_fn.sv
module vlw_lane_fn
    import vlw_pkg::*;
#(
    parameter int EW  = 32,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] din,
    output logic [EW-1:0] dout,
    output vlw_flag_t     flg
);
    vlw_flag_t raw;

    always_comb begin
        raw.inv = din[EW-1] & (|din[EW-2:0]);
        raw.dz  = ~(|din[EW-2:0]);
    end

    generate
        if (LAT == 0) begin : g_comb
            assign dout = din;
            assign flg  = raw;
        end else begin : g_pipe
            typedef struct packed {
                logic [EW-1:0] d;
                vlw_flag_t     f;
            } stage_t;

            stage_t [LAT-1:0] pipe_d, pipe_q;

            always_comb begin
                pipe_d[0] = '{d: din, f: raw};
                for (int k = 1; k < LAT; k++) begin
                    pipe_d[k] = pipe_q[k-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign dout = pipe_q[LAT-1].d;
            assign flg  = pipe_q[LAT-1].f;
        end
    endgenerate

endmodule

// File: rtl/vlw_wb_asm.sv
module vlw_wb_asm #(
    parameter int LANES = 16,
    parameter int EW    = 32
) (
    input  logic [LANES*EW-1:0] res,
    input  logic [LANES-1:0]    inv,
    input  logic [LANES-1:0]    dz,
    input  logic [LANES-1:0]    act,
    input  logic                zero_mode,
    input  logic [LANES*EW-1:0] dest_old,
    output logic [LANES*EW-1:0] dest_new,
    output logic                inv_any,
    output logic                dz_any
);
    generate
        for (genvar j = 0; j < LANES; j++) begin : g_lane
            always_comb begin
                if (act[j]) begin
                    dest_new[j*EW +: EW] = res[j*EW +: EW];
                end else if (zero_mode) begin
                    dest_new[j*EW +: EW] = '0;
                end else begin
                    dest_new[j*EW +: EW] = dest_old[j*EW +: EW];
                end
            end
        end
    endgenerate

    always_comb begin
        inv_any = |(inv & act);
        dz_any  = |(dz & act);
    end

endmodule

// File: rtl/vec_mask_wb.sv
module vec_mask_wb
    import vlw_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int EW     = 32,
    parameter int FN_LAT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LANES*EW-1:0] src,
    input  logic                bcast,
    input  logic                src_is_mem,
    input  logic                mask_none,
    input  logic [LANES-1:0]    mask,
    input  logic                zero_mode,
    output logic                busy,
    output logic                done,
    output logic [LANES*EW-1:0] dest,
    output logic                flag_inv,
    output logic                flag_dz
);
    localparam int VW = LANES * EW;
    localparam int CW = (FN_LAT < 1) ? 1 : $clog2(FN_LAT + 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic             done;
        logic             zero;
        logic [LANES-1:0] act;
        logic [VW-1:0]    ops;
        logic [VW-1:0]    dest;
        logic             finv;
        logic             fdz;
    } state_t;

    state_t st_d, st_q;

    logic [VW-1:0]    sel_ops;
    logic [LANES-1:0] sel_act;
    logic [VW-1:0]    fn_res;
    logic [LANES-1:0] fn_inv;
    logic [LANES-1:0] fn_dz;
    logic [VW-1:0]    wb_dest;
    logic             wb_inv;
    logic             wb_dz;
    logic             last_cyc;

    vlw_opsel #(.LANES(LANES), .EW(EW)) u_opsel (
        .src        (src),
        .bcast      (bcast),
        .src_is_mem (src_is_mem),
        .mask       (mask),
        .mask_none  (mask_none),
        .ops        (sel_ops),
        .act        (sel_act)
    );

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_fn
            vlw_flag_t lane_flg;
            vlw_lane_fn #(.EW(EW), .LAT(FN_LAT)) u_fn (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (st_q.ops[j*EW +: EW]),
                .dout  (fn_res[j*EW +: EW]),
                .flg   (lane_flg)
            );
            assign fn_inv[j] = lane_flg.inv;
            assign fn_dz[j]  = lane_flg.dz;
        end
    endgenerate

    vlw_wb_asm #(.LANES(LANES), .EW(EW)) u_asm (
        .res       (fn_res),
        .inv       (fn_inv),
        .dz        (fn_dz),
        .act       (st_q.act),
        .zero_mode (st_q.zero),
        .dest_old  (st_q.dest),
        .dest_new  (wb_dest),
        .inv_any   (wb_inv),
        .dz_any    (wb_dz)
    );

    always_comb begin
        last_cyc  = (st_q.cnt == CW'(FN_LAT));
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.ops  = sel_ops;
                st_d.act  = sel_act;
                st_d.zero = zero_mode;
            end
        end else if (last_cyc) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            st_d.dest = wb_dest;
            st_d.finv = wb_inv;
            st_d.fdz  = wb_dz;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign dest     = st_q.dest;
    assign flag_inv = st_q.finv;
    assign flag_dz  = st_q.fdz;

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    dest_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(dest));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_cyc) |=> (busy && $stable(st_q.ops) && $stable(st_q.act)));

    // R7
    flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (st_q.act == '0)) |-> (!flag_inv && !flag_dz));

    generate
        for (genvar j = 0; j < LANES; j++) begin : g_chk
            // R5
            merge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (done && !st_q.act[j] && !st_q.zero)
                    |-> (dest[j*EW +: EW] == $past(dest[j*EW +: EW])));

            // R6
            zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (done && !st_q.act[j] && st_q.zero) |-> (dest[j*EW +: EW] == '0));
        end
    endgenerate

endmodule

// File: tb/vec_mask_wb_test.sv
module vec_mask_wb_test;
    localparam int LANES = 16;
    localparam int EW    = 32;
    localparam int VW    = LANES * EW;
    localparam int LAT   = 2;

    typedef struct {
        logic [VW-1:0] dest;
        logic          inv;
        logic          dz;
        int            t0;
        string         req;
    } item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VW-1:0]    src = '0;
    logic             bcast = 1'b0;
    logic             src_is_mem = 1'b0;
    logic             mask_none = 1'b0;
    logic [LANES-1:0] mask = '0;
    logic             zero_mode = 1'b0;
    logic             busy, done, flag_inv, flag_dz;
    logic [VW-1:0]    dest;

    item_t         sb[$];
    logic [VW-1:0] model_dest = '0;
    int            cyc = 0;
    int            n_chk = 0;
    int            n_bad = 0;
    int            n_push = 0;
    int            n_done = 0;
    bit            ended = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vec_mask_wb #(.LANES(LANES), .EW(EW), .FN_LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src(src), .bcast(bcast),
        .src_is_mem(src_is_mem), .mask_none(mask_none), .mask(mask),
        .zero_mode(zero_mode), .busy(busy), .done(done), .dest(dest),
        .flag_inv(flag_inv), .flag_dz(flag_dz)
    );

    task automatic chk(input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] mk_vec(input int seed);
        logic [VW-1:0] v;
        for (int j = 0; j < LANES; j++) begin
            v[j*EW +: EW] = 32'h3F80_0000 + 32'(seed * 256) + 32'(j);
        end
        return v;
    endfunction

    task automatic run(input string req, input logic [VW-1:0] s, input logic b,
                       input logic m, input logic nm, input logic [LANES-1:0] mk,
                       input logic z);
        item_t it;
        logic [EW-1:0] e;
        logic lin, ldz;
        it.inv = 1'b0;
        it.dz  = 1'b0;
        it.req = req;
        for (int j = 0; j < LANES; j++) begin
            e   = (b && m) ? s[EW-1:0] : s[j*EW +: EW];
            lin = e[EW-1] && (e[EW-2:0] != '0);
            ldz = (e[EW-2:0] == '0);
            if (nm || mk[j]) begin
                model_dest[j*EW +: EW] = e;
                it.inv = it.inv | lin;
                it.dz  = it.dz | ldz;
            end else if (z) begin
                model_dest[j*EW +: EW] = '0;
            end
        end
        it.dest = model_dest;
        @(negedge clk);
        while (busy) @(negedge clk);
        src = s; bcast = b; src_is_mem = m; mask_none = nm; mask = mk; zero_mode = z;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        it.t0 = cyc;
        sb.push_back(it);
        n_push++;
    endtask

    always @(negedge clk) begin
        if (rst_n && done) begin
            item_t it;
            n_done++;
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9 unexpected done actual=1 expected=0");
            end else begin
                it = sb.pop_front();
                chk(it.req, "dest", dest, it.dest);
                chk("R7", {it.req, " flag_inv"}, VW'(flag_inv), VW'(it.inv));
                chk("R7", {it.req, " flag_dz"}, VW'(flag_dz), VW'(it.dz));
                chk("R8", {it.req, " latency"}, VW'(cyc - it.t0), VW'(LAT + 1));
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [VW-1:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "dest", dest, '0);
        chk("R10", "flags", VW'({flag_inv, flag_dz}), '0);
        chk("R10", "done/busy", VW'({done, busy}), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 own elements, every lane active
        run("R1", mk_vec(1), 0, 0, 1, '0, 0);
        // R2 broadcast of element 0
        run("R2", mk_vec(2), 1, 1, 1, '0, 0);
        // R3 broadcast request without memory operand has no effect
        run("R3", mk_vec(3), 1, 0, 1, '0, 0);
        // R5 merging keeps inactive lanes
        run("R5", mk_vec(4), 0, 0, 0, 16'hA5C3, 0);
        // R6 zeroing clears inactive lanes
        run("R6", mk_vec(5), 0, 0, 0, 16'h0F0F, 1);
        // R4 mask ignored when no writemask, even under zeroing
        run("R4", mk_vec(6), 0, 0, 1, 16'h0000, 1);
        // R2 broadcast under merge mask
        run("R2", mk_vec(7), 1, 1, 0, 16'h3C01, 0);

        // R7 faulting lanes outside the mask
        v = mk_vec(8);
        v[3*EW +: EW] = 32'hBF80_0000;
        v[5*EW +: EW] = 32'h8000_0000;
        v[9*EW +: EW] = 32'h0000_0000;
        run("R7", v, 0, 0, 0, ~16'h0228, 0);
        // R7 invalid lane inside the mask
        run("R7", v, 0, 0, 0, 16'h0008, 0);
        // R7 divide-by-zero lanes inside the mask
        run("R7", v, 0, 0, 0, 16'h0220, 1);
        // R6 empty mask with zeroing: all cleared, no flags
        run("R6", v, 0, 0, 0, 16'h0000, 1);
        // R7 broadcast of a faulting element 0
        v[EW-1:0] = 32'hFF80_0001;
        run("R7", v, 1, 1, 1, '0, 0);

        // R9 start while busy is ignored
        run("R9", mk_vec(9), 0, 0, 1, '0, 0);
        src = mk_vec(10); mask_none = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        run("R9", mk_vec(11), 0, 0, 0, 16'h00FF, 0);

        repeat (LAT + 6) @(negedge clk);
        chk("R9", "completions", VW'(n_done), VW'(n_push));
        chk("R8", "queue drained", VW'(sb.size()), '0);
        chk("R8", "idle at end", VW'(busy), '0);
        finish_run();
    end

endmodule